// File: doc/BRIEF.md
# Password and Authentication State Tracker

This block holds the security state that decides whether each user zone of a secure memory may currently be read or written. A host presents a 24-bit password against one of eight stored read/write password pairs; a correct match becomes the single active password, and a write password also carries read rights. Separately, the outcome of the external authentication engine arrives as pass/fail pulses with a key index. An encryption-activate request and a message-authentication-code mismatch pulse steer a three-state communication mode.

Every password set and every key has its own consecutive-failure counter. Once a counter reaches the limit, further attempts on that set or key are ignored until reset. A per-zone grant stage combines the active password, the mode and the authenticated key with a static per-zone requirement vector, and registers the read and write grant for each zone. The stored passwords are loaded through a simple write port and survive reset.

Top module: `sec_state_tracker`

## Requirements
- R1: A verify request compares its value with the stored password selected by set index and select bit (0 = read password, 1 = write password); the result is visible on the active-password outputs at the second rising edge after the request cycle.
- R2: Only one password is active. Any verify that is not ignored replaces the previous state, and a mismatch leaves no active password (valid, read and write all 0).
- R3: A matching read password gives read right only; a matching write password gives both read and write rights.
- R4: Each password set has its own count of consecutive failed verifies. A match clears that set's count. After 4 consecutive failures, verifies of that set are ignored and leave the active state unchanged, while other sets still work.
- R5: An authentication pass pulse sets the mode to authenticated (code 1) and records the key. A fail pulse returns the mode to standard (code 0). Each key counts consecutive failures the same way as R4, and once a key is blocked its pulses are ignored.
- R6: An encryption-activate request moves the mode to encrypted (code 2) only when the mode is authenticated or already encrypted. In standard mode it is ignored.
- R7: A MAC mismatch pulse forces the mode to standard at the next edge. It takes priority over a pass pulse or an encryption request in the same cycle.
- R8: A synchronous reset clears the mode to standard, clears the active password and clears all failure counters; stored passwords are kept.
- R9: Zone z is granted read when each of its enabled requirements holds: password (active, set equal to the zone's set, read right), authentication (mode not standard, key equal to the zone's key) and encryption (mode encrypted). Write needs the write right in place of read. Grants are registered one edge after the state.
- R10: Mode codes on `mode_o` are standard = 0, authenticated = 1, encrypted = 2; code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Store-password write enable |
| ld_set | input | 3 | Set index for the store write |
| ld_wsel | input | 1 | 0 = read password, 1 = write password, for the store |
| ld_val | input | 24 | Password value to store |
| vfy_req | input | 1 | Verify request pulse |
| vfy_set | input | 3 | Set index to verify |
| vfy_wsel | input | 1 | 0 = verify read password, 1 = verify write password |
| vfy_val | input | 24 | Presented password value |
| auth_pass | input | 1 | Authentication succeeded pulse |
| auth_fail | input | 1 | Authentication failed pulse |
| auth_key | input | 2 | Key index of the authentication |
| enc_req | input | 1 | Encryption-activate request |
| mac_bad | input | 1 | MAC mismatch pulse |
| zcfg_set | input | 12 | Per-zone required password set, 3 bits per zone |
| zcfg_key | input | 8 | Per-zone required key, 2 bits per zone |
| zcfg_need_pw | input | 4 | Per-zone password requirement enable |
| zcfg_need_auth | input | 4 | Per-zone authentication requirement enable |
| zcfg_need_enc | input | 4 | Per-zone encryption requirement enable |
| act_valid_o | output | 1 | An active password is held |
| act_set_o | output | 3 | Set index of the active password |
| act_rd_o | output | 1 | Active read right |
| act_wr_o | output | 1 | Active write right |
| mode_o | output | 2 | Communication mode code |
| key_o | output | 2 | Key of the last successful authentication |
| zone_rd_o | output | 4 | Per-zone read grant |
| zone_wr_o | output | 4 | Per-zone write grant |

## Verification
A corrupted active-password register shows on `act_valid_o`, `act_rd_o` and `act_wr_o` two edges after the verify that set it, and one edge later in every zone whose requirement names that set. A failure counter that is off by one only shows at the ports when a correct password or a pass pulse is ignored, or accepted, at the wrong attempt, so the bench counts failures up to the limit before each probe. A wrong mode transition shows on `mode_o` at the next edge and on grants of zones needing authentication or encryption one edge later.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } mode_e;
endpackage

// File: rtl/sst_fail_ctr.sv
// Bank of saturating consecutive-failure counters, one per entry.
module sst_fail_ctr #(
  parameter int N     = 8,
  parameter int LIMIT = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic [IW-1:0] idx,
  input  logic          ok,
  output logic [N-1:0]  blocked
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (ev && (idx == IW'(i)) && !blocked[i]) begin
        cnt <= ok ? '0 : cnt + CW'(1);
      end
    end
    assign blocked[i] = (cnt == CW'(LIMIT));
  end
endmodule

// File: rtl/sst_pw_verify.sv
// Password store (inferred RAM, synchronous read) and active-password state.
module sst_pw_verify #(
  parameter int NUM_SETS   = 8,
  parameter int PW_W       = 24,
  parameter int FAIL_LIMIT = 4,
  localparam int SW        = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int DEPTH     = 2 * NUM_SETS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic [SW-1:0]   ld_set,
  input  logic            ld_wsel,
  input  logic [PW_W-1:0] ld_val,
  input  logic            vfy_req,
  input  logic [SW-1:0]   vfy_set,
  input  logic            vfy_wsel,
  input  logic [PW_W-1:0] vfy_val,
  output logic            act_valid,
  output logic [SW-1:0]   act_set,
  output logic            act_rd,
  output logic            act_wr
);
  logic [PW_W-1:0] mem [DEPTH];
  logic [PW_W-1:0] rd_q;

  logic            s1_vld;
  logic [SW-1:0]   s1_set;
  logic            s1_wsel;
  logic [PW_W-1:0] s1_val;

  logic [NUM_SETS-1:0] set_blk;
  logic                cmp_ok;
  logic                cmp_go;

  // RAM: write port for loading, read port for verify
  always_ff @(posedge clk) begin
    if (ld_we) mem[{ld_set, ld_wsel}] <= ld_val;
    if (vfy_req) rd_q <= mem[{vfy_set, vfy_wsel}];
  end

  // Request stage aligned with the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_set  <= '0;
      s1_wsel <= 1'b0;
      s1_val  <= '0;
    end else begin
      s1_vld <= vfy_req;
      if (vfy_req) begin
        s1_set  <= vfy_set;
        s1_wsel <= vfy_wsel;
        s1_val  <= vfy_val;
      end
    end
  end

  assign cmp_ok = (rd_q == s1_val);
  assign cmp_go = s1_vld && !set_blk[s1_set];

  sst_fail_ctr #(.N(NUM_SETS), .LIMIT(FAIL_LIMIT)) u_set_ctr (
    .clk     (clk),
    .rst     (rst),
    .ev      (s1_vld),
    .idx     (s1_set),
    .ok      (cmp_ok),
    .blocked (set_blk)
  );

  // Single active password; a non-ignored attempt always replaces it
  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_set   <= '0;
      act_rd    <= 1'b0;
      act_wr    <= 1'b0;
    end else if (cmp_go) begin
      act_valid <= cmp_ok;
      act_set   <= s1_set;
      act_rd    <= cmp_ok;
      act_wr    <= cmp_ok && s1_wsel;
    end
  end
endmodule

// File: rtl/sst_mode_ctl.sv
// Communication mode, authenticated key and per-key failure counters.
module sst_mode_ctl
  import sst_pkg::*;
#(
  parameter int NUM_KEYS   = 4,
  parameter int FAIL_LIMIT = 4,
  localparam int KW        = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auth_pass,
  input  logic          auth_fail,
  input  logic [KW-1:0] auth_key,
  input  logic          enc_req,
  input  logic          mac_bad,
  output mode_e         mode,
  output logic [KW-1:0] key,
  output logic          sel_blocked
);
  logic [NUM_KEYS-1:0] key_blk;
  logic                attempt;
  logic                good;
  logic                go;

  assign attempt     = auth_pass || auth_fail;
  assign good        = auth_pass && !auth_fail;
  assign sel_blocked = key_blk[auth_key];
  assign go          = attempt && !sel_blocked;

  sst_fail_ctr #(.N(NUM_KEYS), .LIMIT(FAIL_LIMIT)) u_key_ctr (
    .clk     (clk),
    .rst     (rst),
    .ev      (attempt),
    .idx     (auth_key),
    .ok      (good),
    .blocked (key_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_STD;
      key  <= '0;
    end else if (mac_bad) begin
      mode <= MODE_STD;
    end else if (go) begin
      if (good) begin
        mode <= MODE_AUTH;
        key  <= auth_key;
      end else begin
        mode <= MODE_STD;
      end
    end else if (enc_req && (mode != MODE_STD)) begin
      mode <= MODE_ENC;
    end
  end
endmodule

// File: rtl/sst_zone_grant.sv
// Registered per-zone read/write grants.
module sst_zone_grant
  import sst_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int SW        = 3,
  parameter int KW        = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    act_valid,
  input  logic [SW-1:0]           act_set,
  input  logic                    act_rd,
  input  logic                    act_wr,
  input  mode_e                   mode,
  input  logic [KW-1:0]           key,
  input  logic [NUM_ZONES*SW-1:0] zcfg_set,
  input  logic [NUM_ZONES*KW-1:0] zcfg_key,
  input  logic [NUM_ZONES-1:0]    zcfg_need_pw,
  input  logic [NUM_ZONES-1:0]    zcfg_need_auth,
  input  logic [NUM_ZONES-1:0]    zcfg_need_enc,
  output logic [NUM_ZONES-1:0]    zone_rd,
  output logic [NUM_ZONES-1:0]    zone_wr
);
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    logic set_hit, auth_ok, enc_ok, pw_r, pw_w;
    assign set_hit = act_valid && (act_set == zcfg_set[z*SW +: SW]);
    assign pw_r    = !zcfg_need_pw[z] || (set_hit && act_rd);
    assign pw_w    = !zcfg_need_pw[z] || (set_hit && act_wr);
    assign auth_ok = !zcfg_need_auth[z] ||
                     ((mode != MODE_STD) && (key == zcfg_key[z*KW +: KW]));
    assign enc_ok  = !zcfg_need_enc[z] || (mode == MODE_ENC);
    always_ff @(posedge clk) begin
      if (rst) begin
        zone_rd[z] <= 1'b0;
        zone_wr[z] <= 1'b0;
      end else begin
        zone_rd[z] <= pw_r && auth_ok && enc_ok;
        zone_wr[z] <= pw_w && auth_ok && enc_ok;
      end
    end
  end
endmodule

// File: rtl/sec_state_tracker.sv
module sec_state_tracker
  import sst_pkg::*;
#(
  parameter int NUM_SETS   = 8,
  parameter int PW_W       = 24,
  parameter int NUM_KEYS   = 4,
  parameter int NUM_ZONES  = 4,
  parameter int FAIL_LIMIT = 4,
  localparam int SW        = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int KW        = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_we,
  input  logic [SW-1:0]           ld_set,
  input  logic                    ld_wsel,
  input  logic [PW_W-1:0]         ld_val,
  input  logic                    vfy_req,
  input  logic [SW-1:0]           vfy_set,
  input  logic                    vfy_wsel,
  input  logic [PW_W-1:0]         vfy_val,
  input  logic                    auth_pass,
  input  logic                    auth_fail,
  input  logic [KW-1:0]           auth_key,
  input  logic                    enc_req,
  input  logic                    mac_bad,
  input  logic [NUM_ZONES*SW-1:0] zcfg_set,
  input  logic [NUM_ZONES*KW-1:0] zcfg_key,
  input  logic [NUM_ZONES-1:0]    zcfg_need_pw,
  input  logic [NUM_ZONES-1:0]    zcfg_need_auth,
  input  logic [NUM_ZONES-1:0]    zcfg_need_enc,
  output logic                    act_valid_o,
  output logic [SW-1:0]           act_set_o,
  output logic                    act_rd_o,
  output logic                    act_wr_o,
  output logic [1:0]              mode_o,
  output logic [KW-1:0]           key_o,
  output logic [NUM_ZONES-1:0]    zone_rd_o,
  output logic [NUM_ZONES-1:0]    zone_wr_o
);
  mode_e mode_q;
  logic  auth_blocked;

  sst_pw_verify #(
    .NUM_SETS(NUM_SETS), .PW_W(PW_W), .FAIL_LIMIT(FAIL_LIMIT)
  ) u_pw (
    .clk       (clk),
    .rst       (rst),
    .ld_we     (ld_we),
    .ld_set    (ld_set),
    .ld_wsel   (ld_wsel),
    .ld_val    (ld_val),
    .vfy_req   (vfy_req),
    .vfy_set   (vfy_set),
    .vfy_wsel  (vfy_wsel),
    .vfy_val   (vfy_val),
    .act_valid (act_valid_o),
    .act_set   (act_set_o),
    .act_rd    (act_rd_o),
    .act_wr    (act_wr_o)
  );

  sst_mode_ctl #(.NUM_KEYS(NUM_KEYS), .FAIL_LIMIT(FAIL_LIMIT)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .auth_pass   (auth_pass),
    .auth_fail   (auth_fail),
    .auth_key    (auth_key),
    .enc_req     (enc_req),
    .mac_bad     (mac_bad),
    .mode        (mode_q),
    .key         (key_o),
    .sel_blocked (auth_blocked)
  );

  assign mode_o = mode_q;

  sst_zone_grant #(.NUM_ZONES(NUM_ZONES), .SW(SW), .KW(KW)) u_zone (
    .clk            (clk),
    .rst            (rst),
    .act_valid      (act_valid_o),
    .act_set        (act_set_o),
    .act_rd         (act_rd_o),
    .act_wr         (act_wr_o),
    .mode           (mode_q),
    .key            (key_o),
    .zcfg_set       (zcfg_set),
    .zcfg_key       (zcfg_key),
    .zcfg_need_pw   (zcfg_need_pw),
    .zcfg_need_auth (zcfg_need_auth),
    .zcfg_need_enc  (zcfg_need_enc),
    .zone_rd        (zone_rd_o),
    .zone_wr        (zone_wr_o)
  );
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int NUM_ZONES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 auth_fail,
  input logic                 auth_blocked,
  input logic                 enc_req,
  input logic                 mac_bad,
  input logic [1:0]           mode_o,
  input logic                 act_valid_o,
  input logic                 act_rd_o,
  input logic                 act_wr_o,
  input logic [NUM_ZONES-1:0] zone_rd_o,
  input logic [NUM_ZONES-1:0] zone_wr_o
);
  AST_WR_HAS_RD: assert property (@(posedge clk) disable iff (rst)
    act_wr_o |-> act_rd_o); // R3
  AST_RIGHTS_NEED_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    act_rd_o |-> act_valid_o); // R2
  AST_FAIL_DROPS_AUTH: assert property (@(posedge clk) disable iff (rst)
    (auth_fail && !auth_blocked) |=> (mode_o == 2'd0)); // R5
  AST_ENC_FROM_AUTH: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd2) && ($past(mode_o) != 2'd2)) |-> ($past(mode_o) == 2'd1)); // R6
  AST_ENC_IGNORED_IN_STD: assert property (@(posedge clk) disable iff (rst)
    (enc_req && (mode_o == 2'd0)) |=> (mode_o != 2'd2)); // R6
  AST_MAC_TO_STD: assert property (@(posedge clk) disable iff (rst)
    mac_bad |=> (mode_o == 2'd0)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((mode_o == 2'd0) && !act_valid_o)); // R8
  AST_ZONE_WR_HAS_RD: assert property (@(posedge clk) disable iff (rst)
    ((zone_wr_o & ~zone_rd_o) == '0)); // R9
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3); // R10
endmodule

bind sec_state_tracker sst_checker #(.NUM_ZONES(NUM_ZONES)) u_sst_chk (
  .clk          (clk),
  .rst          (rst),
  .auth_fail    (auth_fail),
  .auth_blocked (auth_blocked),
  .enc_req      (enc_req),
  .mac_bad      (mac_bad),
  .mode_o       (mode_o),
  .act_valid_o  (act_valid_o),
  .act_rd_o     (act_rd_o),
  .act_wr_o     (act_wr_o),
  .zone_rd_o    (zone_rd_o),
  .zone_wr_o    (zone_wr_o)
);

// File: tb/tb_sec_state_tracker.sv
module tb_sec_state_tracker;
  localparam int NS = 8, PW = 24, NK = 4, NZ = 4, LIM = 4, SW = 3, KW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic ld_we = 0, ld_wsel = 0, vfy_req = 0, vfy_wsel = 0;
  logic [SW-1:0] ld_set = '0, vfy_set = '0, act_set_o;
  logic [PW-1:0] ld_val = '0, vfy_val = '0;
  logic auth_pass = 0, auth_fail = 0, enc_req = 0, mac_bad = 0;
  logic [KW-1:0] auth_key = '0, key_o;
  logic [NZ*SW-1:0] zcfg_set = '0;
  logic [NZ*KW-1:0] zcfg_key = '0;
  logic [NZ-1:0] zcfg_need_pw = '0, zcfg_need_auth = '0, zcfg_need_enc = '0;
  logic act_valid_o, act_rd_o, act_wr_o;
  logic [1:0] mode_o;
  logic [NZ-1:0] zone_rd_o, zone_wr_o;

  sec_state_tracker dut (.*);

  int n_chk = 0, n_bad = 0;
  // bench model of the requirements
  bit m_valid, m_rd, m_wr;
  int m_set, m_mode, m_key;
  int vcnt[NS];
  int kcnt[NK];
  int zs[NZ], zk[NZ];
  bit zpw[NZ], zau[NZ], zen[NZ];

  function automatic logic [PW-1:0] pw_of(int s, int w);
    return {8'(s * 29 + w * 7 + 11), 8'(s ^ 8'h5A), (w != 0) ? 8'h3C : 8'hC3};
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "act_valid", int'(act_valid_o), int'(m_valid));
    chk(req, "act_rd", int'(act_rd_o), int'(m_rd));
    chk(req, "act_wr", int'(act_wr_o), int'(m_wr));
    if (m_valid) chk(req, "act_set", int'(act_set_o), m_set);
    chk(req, "mode", int'(mode_o), m_mode);
    if (m_mode != 0) chk(req, "key", int'(key_o), m_key);
    for (int z = 0; z < NZ; z++) begin
      bit hit, au, en, er, ew;
      hit = m_valid && (m_set == zs[z]);
      au  = !zau[z] || (m_mode != 0 && m_key == zk[z]);
      en  = !zen[z] || (m_mode == 2);
      er  = (!zpw[z] || (hit && m_rd)) && au && en;
      ew  = (!zpw[z] || (hit && m_wr)) && au && en;
      chk(req, $sformatf("zone_rd[%0d]", z), int'(zone_rd_o[z]), int'(er));
      chk(req, $sformatf("zone_wr[%0d]", z), int'(zone_wr_o[z]), int'(ew));
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_cfg();
    for (int z = 0; z < NZ; z++) begin
      zcfg_set[z*SW +: SW] = SW'(zs[z]);
      zcfg_key[z*KW +: KW] = KW'(zk[z]);
      zcfg_need_pw[z] = zpw[z];
      zcfg_need_auth[z] = zau[z];
      zcfg_need_enc[z] = zen[z];
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_rd = 0; m_wr = 0; m_set = 0; m_mode = 0; m_key = 0;
    for (int i = 0; i < NS; i++) vcnt[i] = 0;
    for (int i = 0; i < NK; i++) kcnt[i] = 0;
  endtask

  task automatic do_reset(string req);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    settle();
    check_state(req);
  endtask

  task automatic do_verify(int s, int w, logic [PW-1:0] v, string req);
    @(negedge clk);
    vfy_req = 1; vfy_set = SW'(s); vfy_wsel = w[0]; vfy_val = v;
    @(negedge clk);
    vfy_req = 0;
    if (vcnt[s] < LIM) begin
      if (v == pw_of(s, w)) begin
        m_valid = 1; m_set = s; m_rd = 1; m_wr = w[0]; vcnt[s] = 0;
      end else begin
        m_valid = 0; m_rd = 0; m_wr = 0; vcnt[s]++;
      end
    end
    settle();
    check_state(req);
  endtask

  task automatic do_sec(int k, bit ap, bit af, bit en, bit mac, string req);
    bit blk;
    @(negedge clk);
    auth_pass = ap; auth_fail = af; auth_key = KW'(k); enc_req = en; mac_bad = mac;
    @(negedge clk);
    auth_pass = 0; auth_fail = 0; enc_req = 0; mac_bad = 0;
    blk = (kcnt[k] >= LIM);
    if ((ap || af) && !blk) kcnt[k] = (ap && !af) ? 0 : kcnt[k] + 1;
    if (mac) m_mode = 0;
    else if ((ap || af) && !blk) begin
      if (ap && !af) begin m_mode = 1; m_key = k; end
      else m_mode = 0;
    end else if (en && m_mode != 0) m_mode = 2;
    settle();
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int z = 0; z < NZ; z++) begin
      zs[z] = 5; zk[z] = 0; zpw[z] = 0; zau[z] = 0; zen[z] = 0;
    end
    // zone 0: password set 5; zone 1: key 2; zone 2: set 5 + key 0 + encryption
    zpw[0] = 1;
    zau[1] = 1; zk[1] = 2;
    zpw[2] = 1; zau[2] = 1; zen[2] = 1;
    apply_cfg();
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    check_state("R8");

    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        ld_we = 1; ld_set = SW'(s); ld_wsel = w[0]; ld_val = pw_of(s, w);
      end
    @(negedge clk); ld_we = 0;

    // R1 and R3: every set and both selects, correct value
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 2; w++) do_verify(s, w, pw_of(s, w), "R3");
    // R1 latency: the result must not appear before the second edge
    @(negedge clk);
    vfy_req = 1; vfy_set = 3'd2; vfy_wsel = 0; vfy_val = pw_of(2, 0);
    @(negedge clk); vfy_req = 0;
    chk("R1", "act_set one edge after request", int'(act_set_o), 7);
    @(negedge clk);
    chk("R1", "act_set two edges after request", int'(act_set_o), 2);
    chk("R1", "act_wr for read password", int'(act_wr_o), 0);
    m_valid = 1; m_set = 2; m_rd = 1; m_wr = 0;
    settle();

    // R2: a mismatch replaces the active password with none
    for (int s = 0; s < NS; s++) begin
      do_verify(s, 1, pw_of(s, 1), "R2");
      do_verify(s, s & 1, pw_of(s, s & 1) ^ PW'(1 << s), "R2");
      do_verify(s, 0, pw_of(s, 0), "R2");
    end

    // R4: per-set limit of 4 consecutive failures
    do_verify(3, 0, pw_of(3, 0) ^ 24'h1, "R4");
    do_verify(3, 0, pw_of(3, 0) ^ 24'h2, "R4");
    do_verify(3, 0, pw_of(3, 0) ^ 24'h4, "R4");
    do_verify(3, 0, pw_of(3, 0), "R4");          // clears count before limit
    do_verify(5, 1, pw_of(5, 1), "R4");
    for (int i = 0; i < 4; i++) do_verify(3, 1, pw_of(3, 1) ^ 24'h800000, "R4");
    do_verify(5, 0, pw_of(5, 0), "R4");
    do_verify(3, 1, pw_of(3, 1), "R4");          // ignored: set 5 stays active
    chk("R4", "blocked set leaves active set", int'(act_set_o), 5);
    do_verify(6, 1, pw_of(6, 1), "R4");          // other sets still accepted

    // R5, R6, R7, R10 directed
    do_sec(2, 1, 0, 0, 0, "R5");
    do_sec(0, 0, 0, 1, 0, "R6");
    chk("R10", "encrypted mode code", int'(mode_o), 2);
    do_sec(0, 0, 0, 0, 1, "R7");
    do_sec(0, 0, 0, 1, 0, "R6");                 // ignored in standard
    do_sec(1, 1, 0, 0, 0, "R5");
    do_sec(1, 0, 1, 0, 0, "R5");
    for (int i = 0; i < 3; i++) do_sec(1, 0, 1, 0, 0, "R5");
    do_sec(1, 1, 0, 0, 0, "R5");                 // key 1 blocked: ignored
    do_sec(0, 1, 0, 0, 0, "R5");
    do_sec(1, 0, 1, 0, 0, "R5");                 // blocked fail keeps mode
    do_sec(3, 1, 0, 1, 1, "R7");                 // mac wins over pass and enc
    do_sec(0, 1, 0, 0, 0, "R9");
    do_sec(0, 0, 0, 1, 0, "R9");

    // R8: reset clears counters but keeps stored passwords
    do_reset("R8");
    do_verify(3, 1, pw_of(3, 1), "R8");
    do_sec(1, 1, 0, 0, 0, "R8");

    // R9: sweep of zone requirements and state sequences
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int op, s, w, k;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      for (int z = 0; z < NZ; z++) begin
        zpw[z] = lf[z];
        zau[z] = lf[z + 4];
        zen[z] = lf[z + 8];
        zs[z] = (int'(lf) >> (z * 3)) & 7;
        zk[z] = (int'(lf) >> (z + 2)) & 3;
      end
      apply_cfg();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[2:0]);
      s  = int'(lf[5:3]);
      w  = int'(lf[6]);
      k  = int'(lf[8:7]);
      if (i % 60 == 59) do_reset("R8");
      else case (op)
        0, 1: do_verify(s, w, pw_of(s, w), "R9");
        2: do_verify(s, w, pw_of(s, w) ^ 24'h10, "R9");
        3, 4: do_sec(k, 1, 0, 0, 0, "R9");
        5: do_sec(k, 0, 1, 0, 0, "R9");
        6: do_sec(k, 0, 0, 1, 0, "R9");
        default: do_sec(k, 0, 0, lf[9], 1, "R9");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule